// File: doc/BRIEF.md
# Audio Control Register Bank with Two-Wire Target

A two-wire serial target that stores the configuration of an audio subsystem and presents every stored field to the amplifier control logic as parallel outputs. A controller selects the device with a fixed 7-bit address, sends one register-pointer byte, and then either streams data bytes into consecutive registers or issues a repeated START and streams register contents back. The pointer advances after every data byte in both directions.

The bank holds twelve registers at pointer values 0 to 11. Pointer 6 is a read-only status register whose bits follow fault inputs from the analog side as they change. The output-control register at pointer 4 carries two special bits. Bit 6 is a one-shot soft reset that reloads every register and never reads back as 1. Bit 5 is the run enable: while it is 0 the bank is in shutdown and every register stays at its default.

SCL and SDA are brought into the system clock domain through flop synchronisers. The system clock must run at least ten times faster than the bus clock.

Top module: `audio_ctrl_regbank`

## Requirements
- R1: After reset, the registers hold these defaults: slot 7 = 0x3F, slots 8 and 9 = 0x01, status reads 0x01 when no fault is present, and all other slots = 0x00. The SDA pull-down is released after reset.
- R2: The first byte after START is compared, MSB first, with the target address 1000001. Bit 0 of that byte selects the direction (0 = write, 1 = read). On a mismatch no ACK is given and the rest of the transfer is ignored until the next START.
- R3: START (SDA falls while SCL is high) restarts byte framing at any point, including in the middle of a byte. STOP (SDA rises while SCL is high) returns the target to idle. A repeated START keeps the register pointer.
- R4: In a write, the second byte sets the pointer from its bits 5:0, and bits 7:6 are ignored. Each later byte is written to the register at the pointer. An accepted byte is acknowledged by holding SDA low during the 9th SCL pulse, and SDA is released after that pulse.
- R5: The pointer increments by one after every data byte, whether written or read, and wraps from 63 to 0.
- R6: A read returns the register at the pointer, MSB first. The target keeps sending bytes while the controller ACKs. After a controller NACK it releases SDA and goes idle.
- R7: Pointer values 12 to 63 are unimplemented. A data byte written there is NACKed and has no effect, and a read there returns 0x00.
- R8: The status register (pointer 6) ignores writes, although the write is ACKed. It reads {2'b00, fault_i[4:0], 1'b1}: each bit 5:1 is 1 only while its fault input is high.
- R9: Writing output control (pointer 4) with bit 6 = 1 restores every register to its default, including output control, which then reads 0x00. Bit 6 never reads back as 1.
- R10: While output-control bit 5 is 0, writes to every register other than output control are ACKed but ignored. A write to output control with bit 5 = 0 restores every register to its default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 10x the bus SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| fault_i | input | 5 | Live fault flags: [0] right headset limit, [1] left headset limit, [2] speaker negative limit, [3] speaker positive limit, [4] supply-regulator setting invalid |
| reg_file_o | output | 96 | Register slot i on bits [8i+7:8i]; slot 6 is the live status value |

## Verification
A wrong stored value or a wrong pointer would be invisible on a single write. It appears on reg_file_o within a few system clocks of the eighth SCL rise of the offending byte, and again on SDA when that register is read back. The bench therefore compares the whole register vector on every clock against a behavioural model. It also reads every slot back over the bus, so pointer faults show up as data landing in the wrong slot. Shutdown, soft reset, the pointer wrap and the unimplemented range each leave a distinct footprint on reg_file_o or in the ACK bit, so a fault in any of them is reported on the first transfer that exercises it.

// File: rtl/audio_regbank_pkg.sv
package audio_regbank_pkg;

  localparam int unsigned IDX_OUT  = 4;
  localparam int unsigned IDX_STAT = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_WR,
    PH_RD
  } phase_e;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      6:       return 8'h01;
      7:       return 8'h3F;
      8, 9:    return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sy, sda_sy;
  logic scl_prev, sda_prev;
  logic scl_lvl, sda_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sy   <= '1;
      sda_sy   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sy   <= {scl_sy[STAGES-2:0], scl_i};
      sda_sy   <= {sda_sy[STAGES-2:0], sda_i};
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_lvl    = scl_sy[STAGES-1];
  assign sda_lvl    = sda_sy[STAGES-1];
  assign sda_o      = sda_lvl;
  assign scl_rise_o = scl_lvl & ~scl_prev;
  assign scl_fall_o = ~scl_lvl & scl_prev;
  assign start_o    = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_o     = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/twi_target_fsm.sv
module twi_target_fsm
  import audio_regbank_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h41
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          hit_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          wr_stb_o,
  output logic [7:0]    wr_data_o,
  output logic          sda_oe_o
);

  phase_e        phase;
  logic [3:0]    cnt;
  logic [6:0]    sr;
  logic [6:0]    tx;
  logic          rw, ack_q, m_ack;
  logic [AW-1:0] ptr;
  logic          sda_oe;
  logic [7:0]    byte_now;

  assign byte_now  = {sr, sda_i};
  assign wr_stb_o  = (phase == PH_WR) && scl_rise_i && (cnt == 4'd7);
  assign wr_data_o = byte_now;
  assign ptr_o     = ptr;
  assign sda_oe_o  = sda_oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      sr     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      ack_q  <= 1'b0;
      m_ack  <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_i) begin
      phase  <= PH_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_i) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise_i) begin
        cnt <= cnt + 4'd1;
        if (cnt < 4'd8) sr <= byte_now[6:0];
        if (cnt == 4'd8) m_ack <= ~sda_i;
        if (cnt == 4'd7) begin
          case (phase)
            PH_DEV: begin
              ack_q <= (byte_now[7:1] == DEV_ADDR);
              rw    <= byte_now[0];
            end
            PH_REG: begin
              ack_q <= 1'b1;
              ptr   <= byte_now[AW-1:0];
            end
            PH_WR: begin
              ack_q <= hit_i;
              ptr   <= ptr + AW'(1);
            end
            PH_RD: begin
              ack_q <= 1'b0;
              ptr   <= ptr + AW'(1);
            end
            default: ack_q <= 1'b0;
          endcase
        end
      end else if (scl_fall_i) begin
        if (cnt == 4'd8) begin
          sda_oe <= ack_q;
        end else if (cnt == 4'd9) begin
          cnt    <= '0;
          sda_oe <= 1'b0;
          case (phase)
            PH_DEV: begin
              if (!ack_q) phase <= PH_IDLE;
              else if (rw) begin
                phase  <= PH_RD;
                tx     <= rd_data_i[6:0];
                sda_oe <= ~rd_data_i[7];
              end else phase <= PH_REG;
            end
            PH_REG: phase <= PH_WR;
            PH_RD: begin
              if (m_ack) begin
                tx     <= rd_data_i[6:0];
                sda_oe <= ~rd_data_i[7];
              end else phase <= PH_IDLE;
            end
            default: ;
          endcase
        end else if (phase == PH_RD && cnt != 4'd0) begin
          sda_oe <= ~tx[6];
          tx     <= {tx[5:0], 1'b0};
        end
      end
    end
  end

  AST_START_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (phase == PH_DEV && cnt == 4'd0 && !sda_oe_o)); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE) |-> !sda_oe_o); // R6
  AST_UNIMPL_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && !hit_i) |=> !ack_q); // R7
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> (ptr == $past(ptr) + AW'(1))); // R5

endmodule

// File: rtl/audio_reg_store.sv
module audio_reg_store
  import audio_regbank_pkg::*;
#(
  parameter int unsigned NREG = 12,
  parameter int unsigned AW   = 6,
  parameter int unsigned NFLT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_stb_i,
  input  logic [7:0]       wr_data_i,
  input  logic [NFLT-1:0]  fault_i,
  output logic             hit_o,
  output logic [7:0]       rd_data_o,
  output logic [NREG*8-1:0] reg_file_o
);

  logic [7:0] view [NREG];
  logic       load_dflt, run;

  assign hit_o     = (addr_i < AW'(NREG));
  assign run       = view[IDX_OUT][5];
  assign load_dflt = wr_stb_i && (addr_i == AW'(IDX_OUT)) && (wr_data_i[6] || !wr_data_i[5]);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == IDX_STAT) begin : g_stat
      assign view[g] = {{(8-NFLT-1){1'b0}}, fault_i, 1'b1};
    end else begin : g_rw
      logic [7:0] q;
      logic       sel;
      assign sel = wr_stb_i && (addr_i == AW'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= reg_default(g);
        else if (load_dflt) q <= reg_default(g);
        else if (sel) begin
          if (g == IDX_OUT) q <= wr_data_i & 8'hBF;
          else if (run)     q <= wr_data_i;
        end
      end
      assign view[g] = q;
    end
    assign reg_file_o[g*8 +: 8] = view[g];
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (addr_i == AW'(i)) rd_data_o = view[i];
  end

  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && addr_i == AW'(IDX_OUT) && wr_data_i[6])
      |=> (view[IDX_OUT] == 8'h00 && view[7] == 8'h3F && view[0] == 8'h00)); // R9
  AST_SHDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !view[IDX_OUT][5] |-> (view[0] == 8'h00 && view[1] == 8'h00 && view[7] == 8'h3F && view[8] == 8'h01)); // R10
  AST_STAT_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && addr_i == AW'(IDX_STAT)) |-> (rd_data_o[0] && rd_data_o[7:6] == 2'b00)); // R8

endmodule

// File: rtl/audio_ctrl_regbank.sv
module audio_ctrl_regbank
  import audio_regbank_pkg::*;
#(
  parameter int unsigned NREG        = 12,
  parameter int unsigned AW          = 6,
  parameter int unsigned NFLT        = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR    = 7'h41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [NFLT-1:0]   fault_i,
  output logic [NREG*8-1:0] reg_file_o
);

  logic          sda_s, scl_rise, scl_fall, start, stop;
  logic          hit, wr_stb;
  logic [7:0]    rd_data, wr_data;
  logic [AW-1:0] ptr;

  twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  twi_target_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .hit_i      (hit),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  audio_reg_store #(.NREG(NREG), .AW(AW), .NFLT(NFLT)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (ptr),
    .wr_stb_i   (wr_stb),
    .wr_data_i  (wr_data),
    .fault_i    (fault_i),
    .hit_o      (hit),
    .rd_data_o  (rd_data),
    .reg_file_o (reg_file_o)
  );

endmodule

// File: tb/test_audio_ctrl_regbank.sv
`timescale 1ns/1ps
module test_audio_ctrl_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int QP   = 8;
  localparam int NREG = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [4:0] fault = '0;
  logic [NREG*8-1:0] regs_o;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = msda & ~sda_oe;

  audio_ctrl_regbank i_audio_ctrl_regbank (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .fault_i(fault), .reg_file_o(regs_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 1'b0;
  logic [7:0] m [NREG];
  int mptr = 0;

  function automatic logic [7:0] dflt(int i);
    if (i == 6) return 8'h01;
    if (i == 7) return 8'h3F;
    if (i == 8 || i == 9) return 8'h01;
    return 8'h00;
  endfunction

  function automatic logic [7:0] status_exp();
    return {2'b00, fault, 1'b1};
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    if (a >= NREG) return 8'h00;
    if (a == 6) return status_exp();
    return m[a];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) m[i] = dflt(i);
  endtask

  task automatic model_write(logic [7:0] d);
    if (mptr < NREG) begin
      if (mptr == 4) begin
        if (d[6] || !d[5]) model_reset();
        else m[4] = d & 8'hBF;
      end else if (mptr != 6 && m[4][5]) m[mptr] = d;
    end
    mptr = (mptr + 1) % 64;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the whole register vector (R1 R8 R9 R10)
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      logic [NREG*8-1:0] e;
      for (int i = 0; i < NREG; i++) e[i*8 +: 8] = (i == 6) ? status_exp() : m[i];
      n_cmp++;
      if (regs_o !== e) begin
        n_bad++;
        $display("FAIL R4/R8/R9/R10 reg vector act %h exp %h", regs_o, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act running exp finished");
    summary();
    $finish;
  end

  task automatic qwait();
    repeat (QP) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    if (scl == 1'b0) begin
      msda = 1'b1; qwait(); scl = 1'b1; qwait();
    end
    msda = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    msda = 1'b0; qwait(); scl = 1'b1; qwait(); msda = 1'b1; qwait();
  endtask

  // mode: 0 plain, 1 register pointer, 2 data write
  task automatic send_byte(logic [7:0] b, int mode, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; qwait();
      if (i == 0) cmp_en = 1'b0;
      scl = 1'b1; qwait();
      if (i == 0) begin
        if (mode == 1) mptr = b[5:0];
        if (mode == 2) model_write(b);
        cmp_en = 1'b1;
      end
      qwait(); scl = 1'b0; qwait();
    end
    msda = 1'b1; qwait(); scl = 1'b1; qwait();
    ack = (sda_bus == 1'b0);
    qwait(); scl = 1'b0; qwait();
  endtask

  task automatic recv_byte(bit nack, output logic [7:0] b);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait(); scl = 1'b1; qwait();
      b[i] = sda_bus;
      qwait(); scl = 1'b0;
    end
    qwait();
    msda = nack; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    msda = 1'b1;
    mptr = (mptr + 1) % 64;
  endtask

  task automatic wr_seq(logic [7:0] ptr_byte, logic [7:0] d[$]);
    bit ack;
    bus_start();
    send_byte(8'h82, 0, ack); chk("R2 device write ack", 8'(ack), 8'd1);
    send_byte(ptr_byte, 1, ack); chk("R4 pointer ack", 8'(ack), 8'd1);
    foreach (d[k]) begin
      bit exp_ack;
      exp_ack = (mptr < NREG);
      send_byte(d[k], 2, ack);
      chk(exp_ack ? "R4 data ack" : "R7 unimplemented nack", 8'(ack), 8'(exp_ack));
    end
    bus_stop();
  endtask

  task automatic rd_seq(logic [5:0] a, int n);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'h82, 0, ack);
    send_byte({2'b00, a}, 1, ack);
    bus_start(); // repeated start keeps pointer (R3)
    send_byte(8'h83, 0, ack); chk("R2 device read ack", 8'(ack), 8'd1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = exp_rd(mptr);
      recv_byte(k == n - 1, b);
      chk("R6 read data", b, e);
    end
    bus_stop();
    chk("R6 sda released after nack", 8'(sda_oe), 8'd0);
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    model_reset();
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sda released", 8'(sda_oe), 8'd0);
    chk("R1 slot7 default", regs_o[7*8 +: 8], 8'h3F);
    chk("R1 status default", regs_o[6*8 +: 8], 8'h01);
    cmp_en = 1'b1;

    // wrong address: ignored (R2)
    bus_start();
    send_byte(8'h84, 0, ack); chk("R2 wrong address nack", 8'(ack), 8'd0);
    send_byte(8'h04, 0, ack); chk("R2 ignored byte nack", 8'(ack), 8'd0);
    bus_stop();

    // leave shutdown, then a burst with pointer bits 7:6 set (R4 R5 R8 R7)
    wr_seq(8'h04, '{8'h20});
    chk("R10 run bit set", regs_o[4*8 +: 8], 8'h20);
    wr_seq(8'hC0, '{8'h15, 8'h27, 8'h33, 8'h08, 8'h2A, 8'h1F, 8'hFF,
                    8'h91, 8'h05, 8'h06, 8'h07, 8'h03, 8'h55});
    chk("R5 auto-increment slot3", regs_o[3*8 +: 8], 8'h08);
    chk("R8 status write ignored", regs_o[6*8 +: 8], 8'h01);

    rd_seq(6'd0, 13);

    // live status (R8)
    #1 fault = 5'b10101;
    rd_seq(6'd6, 1);
    chk("R8 status live", regs_o[6*8 +: 8], 8'h2B);
    fault = 5'b01010;
    rd_seq(6'd6, 1);
    fault = 5'b00000;
    @(negedge clk);
    chk("R8 status clears", regs_o[6*8 +: 8], 8'h01);

    // wrap from 63 to 0 (R5 R7)
    wr_seq(8'h3F, '{8'h77, 8'h44});
    chk("R5 wrap to slot0", regs_o[0 +: 8], 8'h44);
    rd_seq(6'd40, 1);
    rd_seq(6'd62, 4);

    // soft reset (R9)
    wr_seq(8'h04, '{8'h60});
    chk("R9 soft reset out ctrl", regs_o[4*8 +: 8], 8'h00);
    chk("R9 soft reset slot7", regs_o[7*8 +: 8], 8'h3F);

    // shutdown ignores writes (R10)
    wr_seq(8'h01, '{8'h30});
    chk("R10 write ignored in shutdown", regs_o[1*8 +: 8], 8'h00);
    rd_seq(6'd1, 1);
    wr_seq(8'h04, '{8'h2A, 8'h0B});
    wr_seq(8'h01, '{8'h30});
    chk("R10 write taken when running", regs_o[1*8 +: 8], 8'h30);
    wr_seq(8'h04, '{8'h0A});
    chk("R10 shutdown restores slot1", regs_o[1*8 +: 8], 8'h00);
    chk("R10 shutdown restores slot5", regs_o[5*8 +: 8], 8'h00);

    // aborted byte then STOP, next transfer still framed (R3)
    bus_start();
    for (int i = 0; i < 4; i++) begin
      msda = i[0]; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    end
    bus_stop();
    chk("R3 abort leaves sda released", 8'(sda_oe), 8'd0);
    wr_seq(8'h04, '{8'h21, 8'h09});
    chk("R3 framing after abort", regs_o[5*8 +: 8], 8'h09);
    rd_seq(6'd4, 2);

    repeat (20) @(posedge clk);
    summary();
    $finish;
  end

endmodule